// File: doc/BRIEF.md
# Stepped-Profile PWM Sequencer

This block drives a single pulse-width-modulated output whose duty cycle walks through a small table of duty values. The system clock is divided by a fixed prescale constant into a base tick. A PWM period is a runtime-chosen number of base ticks. Each table entry is a duty measured in base ticks, and the generator holds each entry for a chosen number of PWM periods before it moves to the next address.

A sequence either repeats the table without end or makes one pass and then stops, with a busy flag and a one-cycle completion pulse. The run input works in one of two ways. As a level enable, the generator runs while the input is high and stops as soon as it drops. As an edge trigger, only a low-to-high transition starts a sequence. Software-free use is assumed: the table is filled through a plain write port while the generator is idle.

Top module: `pwm_profile_gen`

## Requirements
- R1: After reset, pwmOut, busy and done are all 0.
- R2: A base tick lasts CLK_PER_TICK (default 29) clocks. Within a PWM period of P ticks the output is high for the first D ticks and low for the rest, where D is the current table entry. D=0 gives a constant low and D>=P a constant high.
- R3: The sequence begins at table address 0 and advances by one address after each entry has been held for REP whole PWM periods.
- R4: With singleMode=0 at start, the sequence moves from address LEN-1 back to 0 and continues without end.
- R5: With singleMode=1 at start, busy stays high for exactly LEN*REP*P*CLK_PER_TICK clocks. It then falls, done is high for that one cycle only, and the output is low.
- R6: Level trigger (edgeTrig=0): runIn high while idle starts a sequence on the next clock edge. runIn low while running returns the block to idle one cycle later without a done pulse. After a single pass, runIn must go low before a new start.
- R7: Edge trigger (edgeTrig=1): a start needs a 0-to-1 transition of runIn. Holding runIn high, or toggling it while busy, starts nothing.
- R8: periodCfg, repeatCfg, lengthCfg and singleMode are captured only at start, so changing them mid-sequence has no effect. A value of 0 counts as 1, and a length above DEPTH (252) is clamped to DEPTH.
- R9: A table write (wrEn, wrAddr, wrData) is accepted only while idle. A write while busy changes no entry.
- R10: pwmOut is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runIn | input | 1 | Run level or start trigger, not debounced |
| edgeTrig | input | 1 | 1: runIn is an edge trigger, 0: level enable |
| singleMode | input | 1 | 1: one pass through the table, 0: repeat |
| periodCfg | input | CW (8) | Base ticks per PWM period |
| repeatCfg | input | CW (8) | PWM periods per table entry |
| lengthCfg | input | CW (8) | Number of table entries in use |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | AW (8) | Table write address |
| wrData | input | CW (8) | Duty value in base ticks |
| pwmOut | output | 1 | PWM output |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a single pass |

## Verification
On every cycle the assertions check four things: the period, repeat and address counters stay inside their captured limits, the output is low while idle, done is a lone pulse that only appears as busy falls, and in level mode a dropped run input ends the sequence. The bench scenarios are needed for the rest. These are the exact waveform shape against the table and tick count, the pass length and wrap order, the insensitivity to mid-run setting changes and busy-time writes, and the refusal to start on a held level in edge mode.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture settings and clear counters
    logic run;    // sequence active
  } seqCtl_t;

  // Status from datapath to control
  typedef struct packed {
    logic passEnd;  // last tick of last period of last entry
  } seqStat_t;

endpackage

// File: rtl/pwm_seq_ctrl.sv
module pwm_seq_ctrl
  import pwm_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     runIn,
  input  logic     edgeTrig,
  input  logic     singleMode,
  input  seqStat_t stat,
  output seqCtl_t  ctl,
  output logic     busy,
  output logic     done
);

  logic runSt;
  logic runPrev;
  logic armed;
  logic singleLat;
  logic edgeLat;
  logic startReq;
  logic abortReq;
  logic finishReq;

  always_comb begin
    if (edgeTrig) startReq = !runSt && runIn && !runPrev;
    else          startReq = !runSt && runIn && armed;
    abortReq  = runSt && !edgeLat && !runIn;
    finishReq = runSt && stat.passEnd && singleLat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runSt     <= 1'b0;
      runPrev   <= 1'b0;
      armed     <= 1'b1;
      singleLat <= 1'b0;
      edgeLat   <= 1'b0;
      done      <= 1'b0;
    end else begin
      runPrev <= runIn;
      done    <= 1'b0;
      if (startReq) begin
        runSt     <= 1'b1;
        singleLat <= singleMode;
        edgeLat   <= edgeTrig;
      end else if (abortReq) begin
        runSt <= 1'b0;
      end else if (finishReq) begin
        runSt <= 1'b0;
        done  <= 1'b1;
      end
      if (finishReq && !abortReq) armed <= 1'b0;
      else if (!runIn)            armed <= 1'b1;
    end
  end

  always_comb begin
    ctl.load = startReq;
    ctl.run  = runSt;
    busy     = runSt;
  end

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6
  level_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !edgeLat && !runIn) |=> (!busy && !done));
  // R7
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && edgeTrig && runIn && runPrev) |=> !busy);

endmodule

// File: rtl/pwm_seq_dp.sv
module pwm_seq_dp
  import pwm_seq_pkg::*;
#(
  parameter int CLK_PER_TICK = 29,
  parameter int DEPTH        = 252,
  parameter int CW           = 8,
  parameter int AW           = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqCtl_t       ctl,
  input  logic [CW-1:0] periodCfg,
  input  logic [CW-1:0] repeatCfg,
  input  logic [CW-1:0] lengthCfg,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [CW-1:0] wrData,
  output seqStat_t      stat,
  output logic          pwmOut
);

  localparam int PSW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);

  logic [CW-1:0] dutyTbl [DEPTH];

  logic [CW-1:0] perLat, repLat;
  logic [AW-1:0] lenLat;
  logic [CW-1:0] perEff, repEff;
  logic [AW-1:0] lenEff;

  logic [CW-1:0] tickPos, repCnt;
  logic [AW-1:0] idx;
  logic [CW-1:0] dutyCur;
  logic          tick, perEnd, stepEnd, passEnd;

  // table write port, idle only
  always_ff @(posedge clk) begin
    if (wrEn && !ctl.run && (wrAddr < DEPTH_A)) dutyTbl[wrAddr] <= wrData;
  end

  // setting clamps
  always_comb begin
    perEff = (periodCfg == '0) ? CW'(1) : periodCfg;
    repEff = (repeatCfg == '0) ? CW'(1) : repeatCfg;
    if (lengthCfg == '0)               lenEff = AW'(1);
    else if (int'(lengthCfg) > DEPTH)  lenEff = DEPTH_A;
    else                               lenEff = AW'(lengthCfg);
  end

  // base tick generation
  generate
    if (CLK_PER_TICK > 1) begin : g_presc
      logic [PSW-1:0] presc;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                     presc <= '0;
        else if (ctl.load)             presc <= '0;
        else if (ctl.run) begin
          if (presc == PSW'(CLK_PER_TICK - 1)) presc <= '0;
          else                                  presc <= presc + 1'b1;
        end
      end
      assign tick = ctl.run && (presc == PSW'(CLK_PER_TICK - 1));

      // R2
      presc_range_chk: assert property (@(posedge clk) disable iff (!rstN)
        int'(presc) < CLK_PER_TICK);
    end else begin : g_nopresc
      assign tick = ctl.run;
    end
  endgenerate

  always_comb begin
    perEnd  = tick && (tickPos == perLat - 1'b1);
    stepEnd = perEnd && (repCnt == repLat - 1'b1);
    passEnd = stepEnd && (idx == lenLat - 1'b1);
  end

  // period, repeat and address counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perLat  <= CW'(1);
      repLat  <= CW'(1);
      lenLat  <= AW'(1);
      tickPos <= '0;
      repCnt  <= '0;
      idx     <= '0;
    end else if (ctl.load) begin
      perLat  <= perEff;
      repLat  <= repEff;
      lenLat  <= lenEff;
      tickPos <= '0;
      repCnt  <= '0;
      idx     <= '0;
    end else if (tick) begin
      if (perEnd) begin
        tickPos <= '0;
        if (stepEnd) begin
          repCnt <= '0;
          if (passEnd) idx <= '0;
          else         idx <= idx + 1'b1;
        end else begin
          repCnt <= repCnt + 1'b1;
        end
      end else begin
        tickPos <= tickPos + 1'b1;
      end
    end
  end

  always_comb begin
    dutyCur      = dutyTbl[idx];
    pwmOut       = ctl.run && (tickPos < dutyCur);
    stat.passEnd = passEnd;
  end

  // R2
  tick_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> (tickPos < perLat));
  // R3
  rep_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> (repCnt < repLat));
  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> (idx < lenLat));
  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && passEnd) |=> (idx == '0));

endmodule

// File: rtl/pwm_profile_gen.sv
module pwm_profile_gen
  import pwm_seq_pkg::*;
#(
  parameter int CLK_PER_TICK = 29,
  parameter int DEPTH        = 252,
  parameter int CW           = 8,
  parameter int AW           = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          runIn,
  input  logic          edgeTrig,
  input  logic          singleMode,
  input  logic [CW-1:0] periodCfg,
  input  logic [CW-1:0] repeatCfg,
  input  logic [CW-1:0] lengthCfg,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [CW-1:0] wrData,
  output logic          pwmOut,
  output logic          busy,
  output logic          done
);

  seqCtl_t  ctl;
  seqStat_t stat;

  pwm_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .runIn      (runIn),
    .edgeTrig   (edgeTrig),
    .singleMode (singleMode),
    .stat       (stat),
    .ctl        (ctl),
    .busy       (busy),
    .done       (done)
  );

  pwm_seq_dp #(
    .CLK_PER_TICK (CLK_PER_TICK),
    .DEPTH        (DEPTH),
    .CW           (CW),
    .AW           (AW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .periodCfg (periodCfg),
    .repeatCfg (repeatCfg),
    .lengthCfg (lengthCfg),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .stat      (stat),
    .pwmOut    (pwmOut)
  );

  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !pwmOut);

endmodule

// File: tb/pwm_profile_gen_tb.sv
`timescale 1ns/1ps
module pwm_profile_gen_tb;

  localparam int TICK  = 29;
  localparam int DEPTH = 252;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runIn = 1'b0, edgeTrig = 1'b0, singleMode = 1'b0;
  logic [7:0] periodCfg = 8'd1, repeatCfg = 8'd1, lengthCfg = 8'd1;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0, wrData = '0;
  logic       pwmOut, busy, done;

  int errors = 0;
  int checks = 0;
  int tbl [256];

  always #10 clk = ~clk;

  pwm_profile_gen u_dut (
    .clk(clk), .rstN(rstN), .runIn(runIn), .edgeTrig(edgeTrig),
    .singleMode(singleMode), .periodCfg(periodCfg), .repeatCfg(repeatCfg),
    .lengthCfg(lengthCfg), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit expPwm(int c, int p, int r, int l);
    int t, pos, per, e;
    t   = c / TICK;
    pos = t % p;
    per = t / p;
    e   = (per / r) % l;
    return pos < tbl[e];
  endfunction

  function automatic int pctDuty(int pct10, int p);
    return (pct10 * p + 500) / 1000;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN  = 1'b0;
    runIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeEntry(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'(a); wrData = 8'(d);
    tbl[a] = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Start a sequence and compare every cycle with the bench model.
  task automatic runSeq(input int p, input int r, input int l, input bit single,
                        input bit edgeM, input int obsLen, input string req);
    int pe, re, le, n, limit, bad, badC, badA, badE;
    bit eb, ed, ep;
    pe = (p == 0) ? 1 : p;
    re = (r == 0) ? 1 : r;
    le = (l == 0) ? 1 : ((l > DEPTH) ? DEPTH : l);
    n  = le * re * pe * TICK;
    limit = single ? n + 1 : obsLen;
    bad = 0; badC = 0; badA = 0; badE = 0;
    @(negedge clk);
    periodCfg = 8'(p); repeatCfg = 8'(r); lengthCfg = 8'(l);
    edgeTrig = edgeM; singleMode = single; runIn = 1'b1;
    for (int c = 0; c <= limit; c++) begin
      @(negedge clk);
      eb = single ? (c < n) : 1'b1;
      ed = single && (c == n);
      ep = eb ? expPwm(c, pe, re, le) : 1'b0;
      if ({busy, done, pwmOut} != {eb, ed, ep} && bad == 0) begin
        bad = 1; badC = c;
        badA = {busy, done, pwmOut}; badE = {eb, ed, ep};
      end
      // R9: a busy-time write must not reach the table (model left unchanged)
      if (c == 20) begin wrEn = 1'b1; wrAddr = 8'd0; wrData = 8'(~tbl[0]); end
      if (c == 21) wrEn = 1'b0;
      // R8: new settings mid-run must be ignored
      if (c == 40) begin
        periodCfg = 8'($urandom_range(0, 255));
        repeatCfg = 8'($urandom_range(0, 255));
        lengthCfg = 8'($urandom_range(0, 255));
        singleMode = ~single;
      end
      // R7: toggling the trigger while busy starts nothing new
      if (edgeM && c == 3) runIn = 1'b0;
      if (edgeM && c == 6) runIn = 1'b1;
    end
    check(bad == 0, req, $sformatf("busy,done,pwm at cycle %0d", badC), badA, badE);
    if (single) begin
      // R6 / R7: held-high runIn after a single pass must not restart
      bad = 0;
      for (int c = 0; c < 2 * TICK; c++) begin
        @(negedge clk);
        if (busy || pwmOut || done) bad = 1;
      end
      check(bad == 0, edgeM ? "R7" : "R6", "no restart with runIn held high",
            bad, 0);
      runIn = 1'b0;
      @(negedge clk);
    end else if (!edgeM) begin
      runIn = 1'b0;
      @(negedge clk);
      check({busy, pwmOut, done} == 3'b000, "R6", "level drop stops sequence",
            {busy, pwmOut, done}, 0);
    end else begin
      runIn = 1'b0;
      doReset();
    end
    singleMode = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int pct [5];
    int p, r, l;
    void'($urandom(32'h5eed_0123));
    pct[0] = 250; pct[1] = 500; pct[2] = 875; pct[3] = 125; pct[4] = 750;
    for (int i = 0; i < 256; i++) tbl[i] = 0;

    repeat (2) @(negedge clk);
    check({pwmOut, busy, done} == 3'b000, "R1", "outputs in reset",
          {pwmOut, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({pwmOut, busy, done} == 3'b000, "R1", "outputs after reset",
          {pwmOut, busy, done}, 0);

    // R2 R3 R5: percentage profile at period 31, single pass, level trigger
    for (int i = 0; i < 5; i++) writeEntry(i, pctDuty(pct[i], 31));
    check(tbl[2] == 27, "R2", "scaled duty of 87.5 percent", tbl[2], 27);
    runSeq(31, 1, 5, 1'b1, 1'b0, 0, "R2 R3 R5");

    // R2: duty 0, duty equal to period, duty above period
    writeEntry(0, 0); writeEntry(1, 3); writeEntry(2, 200); writeEntry(3, 1);
    runSeq(3, 2, 4, 1'b1, 1'b1, 0, "R2 R3 R5 R7");

    // R4 R6: continuous wrap, stopped by dropping runIn
    runSeq(2, 2, 4, 1'b0, 1'b0, 2 * 4 * 2 * 2 * TICK + 70, "R4 R6");

    // R4 R7: continuous with edge trigger, stopped by reset
    runSeq(1, 3, 3, 1'b0, 1'b1, 3 * 3 * TICK * 2 + 50, "R4 R7");

    // R8: zero settings count as one
    runSeq(0, 0, 0, 1'b1, 1'b0, 0, "R8");

    // R8: length above table depth is clamped
    for (int i = 0; i < DEPTH; i++) writeEntry(i, $urandom_range(0, 1));
    runSeq(1, 1, 255, 1'b1, 1'b0, 0, "R8 R3");

    // R9: idle write lands in the table
    writeEntry(0, 1);
    runSeq(1, 1, 1, 1'b1, 1'b0, 0, "R9");

    // random profiles
    for (int k = 0; k < 10; k++) begin
      p = $urandom_range(0, 6);
      r = $urandom_range(1, 3);
      l = $urandom_range(1, 5);
      for (int i = 0; i < 5; i++) writeEntry(i, $urandom_range(0, 7));
      if (k % 3 == 2)
        runSeq(p, r, l, 1'b0, 1'b0, 2 * l * r * ((p == 0) ? 1 : p) * TICK + 45,
               "R2 R3 R4 R9");
      else
        runSeq(p, r, l, 1'b1, k[0], 0, "R2 R3 R5 R8");
      @(negedge clk);
      check(!pwmOut && !busy, "R10", "idle output low", pwmOut, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule